// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick count and a compare limit for one processor timer. Both registers are W bits wide, but only the low W-1 bits hold a value. The top bit of each is a control flag. On the count it marks the timer as disabled. On the limit it is an interrupt-disable bit. Any write to either register copies its top bit into one shared disabled state. The counter advances by one on every cycle where the tick-enable strobe is high. That strobe comes from a 100 MHz time base outside the block, and the counter keeps running while the timer is disabled.

Writing a nonzero limit with the top bit clear arms a single compare event. The event fires on the tick that brings the count up to the limit. If the limit written is at or below the count at the moment of the write, the event fires on the very next tick instead of waiting for the counter to wrap. A fired event sets a sticky match flag that feeds the soft-interrupt logic, and it pulses a wake output for one cycle. If the timer is disabled when the event comes due, the event is used up and has no effect. Software clears the flag through a clear input.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count value and the limit value are zero, the timer is disabled, the limit control bit is zero, and matchFlag and wake are low. A count read therefore returns only the top bit set.
- R2: A count write (wrEn=1, wrSel=0) loads wrData[W-2:0] into the count and copies wrData[W-1] into the disabled state. A count read (rdSel=0) returns {disabled, count}.
- R3: On each cycle with tickEn=1 and wrEn=0 the count goes up by one, whether or not the timer is disabled. From all ones it wraps to zero and the control bit is not changed. On any other cycle the count holds.
- R4: A limit write (wrEn=1, wrSel=1) stores wrData[W-2:0] as the limit and wrData[W-1] as the limit control bit, and copies wrData[W-1] into the disabled state. A limit read (rdSel=1) returns {limit control bit, limit}.
- R5: After a limit write with a nonzero value and the top bit clear, the tick that makes the count equal to the limit fires one event. That event raises matchFlag and pulses wake on the same clock edge. The compare then stays inactive until the next limit write.
- R6: A limit write with a zero value, or with the top bit set, cancels any armed compare. No event follows it.
- R7: An armed limit that is at or below the count at the moment it was written fires on the first tick after the write.
- R8: An event that comes due while the timer is disabled is consumed. It sets no flag and gives no wake pulse, and it does not fire again after the timer is re-enabled.
- R9: matchFlag stays high until matchClr is asserted with no event in the same cycle. Events that come while the flag is high still pulse wake and leave the flag high. An event in the same cycle as matchClr wins, so the flag stays set.
- R10: In a cycle with wrEn=1, tickEn is ignored. The count does not advance and no compare event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advance strobe from the time base |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = count, 1 = limit |
| wrData | input | W | Write data; top bit is the control flag |
| rdSel | input | 1 | Read source: 0 = count, 1 = limit |
| rdData | output | W | Read data, combinational from the registers |
| matchClr | input | 1 | Clears the match flag |
| matchFlag | output | 1 | Sticky match flag |
| wake | output | 1 | One-cycle pulse for each enabled event |

## Verification
The hardest case to reach from the ports is the late-limit path. In this case the limit is written at or below the running count, so the event must fire on the next tick and not after a full wrap. It is easy to confuse with an ordinary match one tick ahead. The bench runs with a six-bit configuration, which gives five value bits. It sweeps every pair of nonzero limit and start count. For each pair it counts the ticks to the wake pulse and compares that number with 1 when the limit is at or below the start, and with the difference of the two otherwise. Separate sequences arm a limit and then disable the timer before the event comes due, and line up a clear with a firing tick.

// File: rtl/tick_pkg.sv
package tick_pkg;

  // Strobes that the control sends to the datapath in each cycle
  typedef struct packed {
    logic loadCount;
    logic loadLimit;
    logic incr;
  } tickStrobe_t;

  // Compare and write-decode status that the datapath returns to the control
  typedef struct packed {
    logic hitNext;      // count + 1 equals the limit
    logic limitBehind;  // written limit value is at or below the count
    logic limitZero;    // written limit value is zero
    logic wrCtl;        // control bit of the write data
    logic disabled;     // current disabled state
  } tickStatus_t;

endpackage

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  tickStrobe_t  strobe,
  input  logic [W-1:0] wrData,
  input  logic         rdSel,
  output logic [W-1:0] rdData,
  output tickStatus_t  status,
  output logic [W-2:0] countVal
);
  localparam int VW = W - 1;
  localparam logic [VW-1:0] ONE = VW'(1);

  logic [VW-1:0] countQ, limitQ, countNext, wrVal;
  logic          limitCtlQ, disabledQ, wrCtl;

  assign wrVal     = wrData[VW-1:0];
  assign wrCtl     = wrData[W-1];
  assign countNext = countQ + ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      limitQ    <= '0;
      limitCtlQ <= 1'b0;
      disabledQ <= 1'b1;
    end else begin
      if (strobe.loadCount)  countQ <= wrVal;
      else if (strobe.incr)  countQ <= countNext;
      if (strobe.loadLimit) begin
        limitQ    <= wrVal;
        limitCtlQ <= wrCtl;
      end
      if (strobe.loadCount || strobe.loadLimit) disabledQ <= wrCtl;
    end
  end

  always_comb begin
    status.hitNext     = (countNext == limitQ);
    status.limitBehind = (wrVal <= countQ);
    status.limitZero   = (wrVal == '0);
    status.wrCtl       = wrCtl;
    status.disabled    = disabledQ;
  end

  assign rdData   = rdSel ? {limitCtlQ, limitQ} : {disabledQ, countQ};
  assign countVal = countQ;

endmodule

// File: rtl/tick_control.sv
module tick_control
  import tick_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic        matchClr,
  input  tickStatus_t status,
  output tickStrobe_t strobe,
  output logic        matchFlag,
  output logic        wake,
  output logic        armed
);
  logic armedQ, pastQ, flagQ, wakeQ;
  logic hit, fire, armNew;

  always_comb begin
    strobe.loadCount = wrEn & ~wrSel;
    strobe.loadLimit = wrEn & wrSel;
    strobe.incr      = tickEn & ~wrEn;
  end

  assign hit    = strobe.incr & armedQ & (pastQ | status.hitNext);
  assign fire   = hit & ~status.disabled;
  assign armNew = ~status.limitZero & ~status.wrCtl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      pastQ  <= 1'b0;
      flagQ  <= 1'b0;
      wakeQ  <= 1'b0;
    end else begin
      if (strobe.loadLimit) begin
        armedQ <= armNew;
        pastQ  <= armNew & status.limitBehind;
      end else if (hit) begin
        armedQ <= 1'b0;
        pastQ  <= 1'b0;
      end
      flagQ <= fire | (flagQ & ~matchClr);
      wakeQ <= fire;
    end
  end

  assign matchFlag = flagQ;
  assign wake      = wakeQ;
  assign armed     = armedQ;

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [W-1:0] wrData,
  input  logic         rdSel,
  output logic [W-1:0] rdData,
  input  logic         matchClr,
  output logic         matchFlag,
  output logic         wake
);
  tickStrobe_t  strobe;
  tickStatus_t  status;
  logic [W-2:0] countVal;
  logic         disabled, armed;

  assign disabled = status.disabled;

  tick_control i_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .matchClr(matchClr), .status(status), .strobe(strobe),
    .matchFlag(matchFlag), .wake(wake), .armed(armed)
  );

  tick_datapath #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .status(status), .countVal(countVal)
  );

endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rstN,
  input logic         tickEn,
  input logic         wrEn,
  input logic         matchClr,
  input logic         matchFlag,
  input logic         wake,
  input logic [W-2:0] countVal,
  input logic         disabled,
  input logic         armed
);
  localparam int VW = W - 1;
  localparam logic [VW-1:0] ONE = VW'(1);

  AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> matchFlag); // R5
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> !armed); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !matchClr) |=> matchFlag); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    matchClr |=> (!matchFlag || wake)); // R9
  AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> !disabled); // R8
  AST_WRITE_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wake); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrEn) |=> (countVal == ($past(countVal) + ONE))); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> $stable(countVal)); // R3

endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.W(W)) i_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .matchClr(matchClr),
  .matchFlag(matchFlag), .wake(wake), .countVal(countVal),
  .disabled(disabled), .armed(armed)
);

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;
  localparam int W = 6;
  localparam int VM = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0, matchClr = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic matchFlag, wake;

  int vectors = 0;
  int miscompares = 0;
  int mCount, mLimit, mLimCtl, mDis, mArmed, mPast, mFlag, mWake;
  int lastWake, anyWake;

  always #4 clk = ~clk;

  tick_cmp_timer #(.W(W)) i_tick_cmp_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .matchClr(matchClr),
    .matchFlag(matchFlag), .wake(wake)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    rdSel = 1'b0; #1;
    chk(tag, "count read", int'(rdData), mDis * 32 + mCount);
    rdSel = 1'b1; #1;
    chk(tag, "limit read", int'(rdData), mLimCtl * 32 + mLimit);
    chk(tag, "wake", int'(wake), mWake);
    chk(tag, "matchFlag", int'(matchFlag), mFlag);
  endtask

  // One clock: drive at the falling edge, update the model, check after the rising edge
  task automatic cyc(input logic tk, input logic we, input logic ws,
                     input logic [W-1:0] wd, input logic clr, input string tag);
    int oldCount, wv, incr, hitN, hit, fire;
    tickEn = tk; wrEn = we; wrSel = ws; wrData = wd; matchClr = clr;
    oldCount = mCount;
    wv = int'(wd) & VM;
    incr = (tk && !we) ? 1 : 0;
    hitN = (((mCount + 1) & VM) == mLimit) ? 1 : 0;
    hit = (incr != 0 && mArmed != 0 && (mPast != 0 || hitN != 0)) ? 1 : 0;
    fire = (hit != 0 && mDis == 0) ? 1 : 0;
    if (we && !ws) mCount = wv;
    else if (incr != 0) mCount = (mCount + 1) & VM;
    if (we && ws) begin
      mLimit = wv;
      mLimCtl = int'(wd[W-1]);
      mArmed = (wv != 0 && !wd[W-1]) ? 1 : 0;
      mPast = (mArmed != 0 && wv <= oldCount) ? 1 : 0;
    end else if (hit != 0) begin
      mArmed = 0;
      mPast = 0;
    end
    if (we) mDis = int'(wd[W-1]);
    mFlag = (fire != 0 || (mFlag != 0 && !clr)) ? 1 : 0;
    mWake = fire;
    @(posedge clk); #1;
    checkAll(tag);
    lastWake = int'(wake);
    if (wake) anyWake = 1;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0; matchClr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mCount = 0; mLimit = 0; mLimCtl = 0; mDis = 1; mArmed = 0; mPast = 0;
    mFlag = 0; mWake = 0; lastWake = 0; anyWake = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    checkAll("R1");
    @(negedge clk);

    // R2 every count write value, read back
    for (int v = 0; v < 64; v++) cyc(1'b0, 1'b1, 1'b0, 6'(v), 1'b0, "R2");
    // R4 every limit write value, read back
    for (int v = 0; v < 64; v++) cyc(1'b0, 1'b1, 1'b1, 6'(v), 1'b0, "R4");
    cyc(1'b0, 1'b0, 1'b0, 6'd0, 1'b1, "R9");

    // R5 / R7 sweep all nonzero limits against all start counts
    for (int l = 1; l <= VM; l++) begin
      for (int c = 0; c <= VM; c++) begin
        int n, expN;
        string tag;
        tag = (l <= c) ? "R7" : "R5";
        expN = (l <= c) ? 1 : (l - c);
        cyc(1'b0, 1'b1, 1'b0, 6'(c), 1'b0, tag);
        cyc(1'b0, 1'b1, 1'b1, 6'(l), 1'b0, tag);
        n = 0;
        for (int k = 0; k < 40; k++) begin
          cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, tag);
          n++;
          if (lastWake != 0) break;
        end
        chk(tag, "ticks to event", n, expN);
        cyc(1'b0, 1'b0, 1'b0, 6'd0, 1'b1, "R9");
      end
    end

    // R6 zero limit and limit with control bit never fire
    anyWake = 0;
    cyc(1'b0, 1'b1, 1'b0, 6'd3, 1'b0, "R6");
    cyc(1'b0, 1'b1, 1'b1, 6'd0, 1'b0, "R6");
    for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R6");
    cyc(1'b0, 1'b1, 1'b1, 6'h25, 1'b0, "R6");
    cyc(1'b0, 1'b1, 1'b0, 6'd0, 1'b0, "R6");
    for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R6");
    chk("R6", "any wake", anyWake, 0);

    // R8 event due while disabled is consumed
    anyWake = 0;
    cyc(1'b0, 1'b1, 1'b0, 6'd0, 1'b0, "R8");
    cyc(1'b0, 1'b1, 1'b1, 6'd5, 1'b0, "R8");
    cyc(1'b0, 1'b1, 1'b0, 6'h22, 1'b0, "R8");
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R8");
    cyc(1'b0, 1'b1, 1'b0, 6'd0, 1'b0, "R8");
    for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R8");
    chk("R8", "any wake", anyWake, 0);
    chk("R8", "flag", int'(matchFlag), 0);

    // R9 sticky flag, absorbed match, event beats clear
    cyc(1'b0, 1'b1, 1'b0, 6'd0, 1'b0, "R9");
    cyc(1'b0, 1'b1, 1'b1, 6'd2, 1'b0, "R9");
    cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R9");
    cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R9");
    chk("R9", "flag after match", int'(matchFlag), 1);
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "R9");
    cyc(1'b0, 1'b1, 1'b1, 6'd1, 1'b0, "R9");
    cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R9");
    chk("R9", "absorbed wake", lastWake, 1);
    cyc(1'b0, 1'b1, 1'b1, 6'd4, 1'b0, "R9");
    cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b1, "R9");
    chk("R9", "flag set beats clear", int'(matchFlag), 1);
    cyc(1'b0, 1'b0, 1'b0, 6'd0, 1'b1, "R9");
    chk("R9", "flag cleared", int'(matchFlag), 0);

    // R10 writes override the tick
    cyc(1'b0, 1'b1, 1'b1, 6'd8, 1'b0, "R10");
    cyc(1'b1, 1'b1, 1'b0, 6'd7, 1'b0, "R10");
    cyc(1'b1, 1'b1, 1'b1, 6'd8, 1'b0, "R10");
    chk("R10", "no wake on write", lastWake, 0);
    cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R10");
    chk("R10", "wake after write", lastWake, 1);
    cyc(1'b0, 1'b0, 1'b0, 6'd0, 1'b1, "R10");

    // R3 wrap keeps the control bit, counting while disabled, idle hold
    cyc(1'b0, 1'b1, 1'b0, 6'h3F, 1'b0, "R3");
    cyc(1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R3");
    rdSel = 1'b0; #1;
    chk("R3", "wrap read", int'(rdData), 32);
    for (int k = 0; k < 6; k++) cyc(k[0], 1'b0, 1'b0, 6'd0, 1'b0, "R3");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule